// File: doc/BRIEF.md
# SPI Master/Slave Transceiver

This block moves one byte at a time over a four-wire synchronous serial link. A single 8-bit control word, written and read back through a plain register port, turns the engine on, picks master or slave role, selects which end of the byte goes first, and sets the clock polarity, clock phase and the master's serial clock rate. The rate is a three-bit code: a doubling bit and a two-bit divisor select.

As master, the block divides the system clock to make the serial clock, shifts data out on its data-out pin and samples the peer's reply. A transfer starts when a byte is accepted on the transmit stream. As slave, it passes the external serial clock, the active-low select and the incoming data through a synchronizer. It shifts its preloaded byte out and the incoming byte in, edge by edge, while the select is held low.

Transmit data is a valid/ready stream. A byte is taken only in a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is low while the engine is disabled, while a transfer is running, and in any cycle that writes the control word, so the source must hold the byte until it is accepted. Receive data has no back-pressure: `rx_valid` is a single-cycle strobe, and `rx_data` holds the byte until the next transfer completes.

Top module: `spi_xcvr`

## Requirements
- R1: After reset the control word reads 0x00, and `busy`, `rx_valid`, `tx_ready` and `sck_out` are all low.
- R2: The control word reads back as written. Its bit fields are: bit 7 enable, bit 6 LSB-first (0 = MSB first), bit 5 master (0 = slave), bit 4 CPOL, bit 3 CPHA, bit 2 double-speed, bits 1:0 rate.
- R3: While the enable bit is 0, `tx_ready` stays low, an offered byte is ignored, `busy` stays low and `sck_out` stays at its idle level.
- R4: Whenever no transfer runs, `sck_out` equals CPOL.
- R5: As master, each half period of `sck_out` lasts H system clocks, and the first edge comes H clocks after the byte is accepted. With double-speed 0, rate codes 0..3 give H = 2, 8, 32, 64. With double-speed 1, they give H = 1, 4, 16, 32.
- R6: Edges are numbered 1..16, and the odd-numbered edges are the leading edges. With CPHA=0, data is sampled on the leading edges and changes on the trailing edges, and the first bit is on `mosi_out` from the accept cycle onward. With CPHA=1, data changes on the leading edges and is sampled on the trailing edges. Each transfer has exactly 16 edges.
- R7: With LSB-first 1, bit 0 travels first; otherwise bit 7 travels first. The same order applies to transmitted and received bits.
- R8: `tx_ready` = enabled AND not busy AND no control write in that cycle. An accepted byte in master mode raises `busy` in the next cycle.
- R9: On the 16th edge, `rx_valid` pulses for exactly one cycle, `rx_data` takes the received byte and `busy` falls in the same cycle.
- R10: In slave mode, a falling select starts a transfer that shifts out the byte last accepted on the stream. The transfer follows the external clock edges. Raising the select before the 16th edge abandons the transfer with no `rx_valid`.
- R11: A control write during a transfer aborts it: `busy` falls, `sck_out` returns to the new CPOL, and no `rx_valid` follows.
- R12: A control write and an offered byte in the same cycle: the control write wins and the byte is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word write value |
| ctrl_rdata | output | 8 | Current control word |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | DATA_W | Transmit byte |
| tx_ready | output | 1 | Transmit byte can be accepted |
| busy | output | 1 | Transfer in progress |
| rx_valid | output | 1 | One-cycle transfer-complete strobe |
| rx_data | output | DATA_W | Last received byte |
| sck_out | output | 1 | Serial clock driven in master mode |
| mosi_out | output | 1 | Serial data out in master mode |
| miso_in | input | 1 | Serial data in, master mode |
| sck_in | input | 1 | External serial clock, slave mode |
| ss_n_in | input | 1 | External active-low select, slave mode |
| mosi_in | input | 1 | Serial data in, slave mode |
| miso_out | output | 1 | Serial data out, slave mode |

## Verification
Two events can land in the same clock cycle: a control-word write and a transmit handshake. The control write must win, so no transfer starts and the new configuration takes effect. The bench drives both strobes at the same falling edge. It then checks at the ports that `tx_ready` dropped in that cycle, that `busy` never rose, and that the control word and the idle clock level match the value written. A related collision, a control write landing mid-transfer, is judged by `busy` falling at once and by no completion strobe appearing over a window longer than the slowest transfer.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

  typedef struct packed {
    logic       en;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic       dbl;
    logic [1:0] rate;
  } spi_ctrl_t;

  localparam int HALF_W = 7;

  // Half period of the serial clock in system clocks: log2(divisor) is
  // 2,4,6,7 for rate 0..3; double speed removes one power of two.
  function automatic logic [HALF_W-1:0] half_period(input logic dbl, input logic [1:0] rate);
    int lg;
    case (rate)
      2'd0:    lg = 2;
      2'd1:    lg = 4;
      2'd2:    lg = 6;
      default: lg = 7;
    endcase
    lg = lg - int'(dbl);
    return HALF_W'(1 << (lg - 1));
  endfunction

endpackage

// File: rtl/spi_xcvr_sync.sv
module spi_xcvr_sync #(
  parameter int             WIDTH   = 3,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[gi] <= RST_VAL;
        else if (gi == 0) stg[gi] <= d;
        else stg[gi] <= stg[(gi == 0) ? 0 : gi - 1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_xcvr_baud.sv
module spi_xcvr_baud #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == half - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!run)  cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_xcvr_shift.sv
module spi_xcvr_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         lsb_first,
  input  logic         shift_en,
  input  logic         sample_en,
  input  logic         in_bit,
  output logic         out_bit,
  output logic [W-1:0] rx_next
);
  logic [W-1:0] tx_q, rx_q;

  assign out_bit = lsb_first ? tx_q[0] : tx_q[W-1];

  always_comb begin
    rx_next = rx_q;
    if (sample_en)
      rx_next = lsb_first ? {in_bit, rx_q[W-1:1]} : {rx_q[W-2:0], in_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      rx_q <= rx_next;
      if (load)          tx_q <= load_data;
      else if (shift_en) tx_q <= lsb_first ? (tx_q >> 1) : (tx_q << 1);
    end
  end
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_xcvr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [7:0]        ctrl_wdata,
  output logic [7:0]        ctrl_rdata,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              busy,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              sck_out,
  output logic              mosi_out,
  input  logic              miso_in,
  input  logic              sck_in,
  input  logic              ss_n_in,
  input  logic              mosi_in,
  output logic              miso_out
);
  localparam int LAST_EDGE = 2 * DATA_W;
  localparam int EDGE_W    = $clog2(LAST_EDGE + 1);

  spi_ctrl_t         ctrl_q;
  logic              busy_q, sck_q, rxv_q;
  logic [DATA_W-1:0] rxd_q;
  logic [EDGE_W-1:0] edge_cnt_q, edge_nxt;
  logic              sck_s, ss_s, mosi_s, sck_prev_q, ss_prev_q;
  logic              tick, accept, start_m, slave_start, slave_abort;
  logic              edge_ev, is_sample, sample_ev, shift_ev, last_ev;
  logic              out_bit, in_bit;
  logic [DATA_W-1:0] rx_next;

  // External slave-side pins into the system clock domain.
  spi_xcvr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({sck_in, ss_n_in, mosi_in}),
    .q({sck_s, ss_s, mosi_s})
  );

  spi_xcvr_baud #(.CNT_W(HALF_W)) baud_i (
    .clk(clk), .rst_n(rst_n),
    .run(busy_q && ctrl_q.master),
    .half(half_period(ctrl_q.dbl, ctrl_q.rate)),
    .tick(tick)
  );

  spi_xcvr_shift #(.W(DATA_W)) shift_i (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .load_data(tx_data),
    .lsb_first(ctrl_q.lsb_first),
    .shift_en(shift_ev), .sample_en(sample_ev),
    .in_bit(in_bit), .out_bit(out_bit), .rx_next(rx_next)
  );

  assign tx_ready    = ctrl_q.en && !busy_q && !ctrl_we;
  assign accept      = tx_valid && tx_ready;
  assign start_m     = accept && ctrl_q.master;
  assign slave_start = ctrl_q.en && !ctrl_q.master && !busy_q && ss_prev_q && !ss_s;
  assign slave_abort = busy_q && !ctrl_q.master && ss_s;

  // One serial clock edge, generated (master) or observed (slave).
  assign edge_ev   = busy_q && (ctrl_q.master ? tick : (sck_s != sck_prev_q));
  assign edge_nxt  = edge_cnt_q + 1'b1;
  assign is_sample = edge_nxt[0] ^ ctrl_q.cpha;
  assign sample_ev = edge_ev && is_sample;
  assign shift_ev  = edge_ev && !is_sample && (edge_nxt != EDGE_W'(1))
                     && (edge_nxt != EDGE_W'(LAST_EDGE));
  assign last_ev   = edge_ev && (edge_nxt == EDGE_W'(LAST_EDGE));
  assign in_bit    = ctrl_q.master ? miso_in : mosi_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev_q <= 1'b0;
      ss_prev_q  <= 1'b1;
    end else begin
      sck_prev_q <= sck_s;
      ss_prev_q  <= ss_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      busy_q     <= 1'b0;
      edge_cnt_q <= '0;
      sck_q      <= 1'b0;
      rxv_q      <= 1'b0;
      rxd_q      <= '0;
    end else begin
      rxv_q <= 1'b0;
      if (ctrl_we) begin
        ctrl_q     <= spi_ctrl_t'(ctrl_wdata);
        busy_q     <= 1'b0;
        edge_cnt_q <= '0;
        sck_q      <= ctrl_wdata[4];
      end else if (start_m) begin
        busy_q     <= 1'b1;
        edge_cnt_q <= '0;
        sck_q      <= ctrl_q.cpol;
      end else if (slave_start) begin
        busy_q     <= 1'b1;
        edge_cnt_q <= '0;
      end else if (slave_abort) begin
        busy_q     <= 1'b0;
        edge_cnt_q <= '0;
      end else if (edge_ev) begin
        edge_cnt_q <= edge_nxt;
        if (ctrl_q.master) sck_q <= ~sck_q;
        if (last_ev) begin
          busy_q     <= 1'b0;
          rxv_q      <= 1'b1;
          rxd_q      <= rx_next;
          edge_cnt_q <= '0;
        end
      end
    end
  end

  assign ctrl_rdata = ctrl_q;
  assign busy       = busy_q;
  assign rx_valid   = rxv_q;
  assign rx_data    = rxd_q;
  assign sck_out    = sck_q;
  assign mosi_out   = out_bit;
  assign miso_out   = out_bit;
endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_we,
  input logic [7:0] ctrl_rdata,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       busy,
  input logic       rx_valid,
  input logic       sck_out
);
  assert_disabled_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[7] |-> (!tx_ready && !busy));

  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck_out == ctrl_rdata[4]));

  assert_master_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && ctrl_rdata[5]) |=> busy);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_done_clears_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !busy);

  assert_ctrl_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (!busy && !rx_valid));
endmodule

bind spi_xcvr spi_xcvr_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_rdata(ctrl_rdata),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .busy(busy),
  .rx_valid(rx_valid), .sck_out(sck_out)
);

// File: tb/spi_xcvr_tb_top.sv
`timescale 1ns/1ps
module spi_xcvr_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_we = 1'b0, tx_valid = 1'b0;
  logic [7:0] ctrl_wdata = '0, tx_data = '0;
  logic [7:0] ctrl_rdata, rx_data;
  logic tx_ready, busy, rx_valid, sck_out, mosi_out, miso_out;
  logic miso_in, sck_in = 1'b0, ss_n_in = 1'b1, mosi_in = 1'b0;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] cur_ctrl = '0, bench_miso = '0, mon_mosi = '0, rx_cap = '0;
  logic mon_en = 1'b0, sck_q = 1'b0, prev_rxv = 1'b0;
  int mon_edges = 0, mon_k = 0, mon_last = 0, gap_err = 0, h_exp = 1;
  int done_cnt = 0, width_err = 0;

  always #5 clk = ~clk;

  spi_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .busy(busy), .rx_valid(rx_valid), .rx_data(rx_data),
    .sck_out(sck_out), .mosi_out(mosi_out), .miso_in(miso_in),
    .sck_in(sck_in), .ss_n_in(ss_n_in), .mosi_in(mosi_in), .miso_out(miso_out)
  );

  function automatic int bitpos(input logic lsb, input int k);
    return lsb ? k : 7 - k;
  endfunction

  function automatic int exp_half(input logic dbl, input logic [1:0] rate);
    case ({dbl, rate})
      3'b000: return 2;   3'b001: return 8;
      3'b010: return 32;  3'b011: return 64;
      3'b100: return 1;   3'b101: return 4;
      3'b110: return 16;  default: return 32;
    endcase
  endfunction

  always_comb miso_in = (mon_k < 8) ? bench_miso[bitpos(cur_ctrl[6], mon_k)] : 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Port monitor: completion strobes and master-side serial edges.
  always @(negedge clk) begin
    if (rx_valid) begin
      done_cnt = done_cnt + 1;
      rx_cap = rx_data;
      if (prev_rxv) width_err = width_err + 1;
    end
    prev_rxv = rx_valid;
    if (mon_en && sck_out !== sck_q) begin
      if (cyc - mon_last != h_exp) gap_err = gap_err + 1;
      mon_last = cyc;
      if ((((mon_edges + 1) % 2) == 1) ^ cur_ctrl[3]) begin
        if (mon_k < 8) mon_mosi[bitpos(cur_ctrl[6], mon_k)] = mosi_out;
        mon_k = mon_k + 1;
      end
      mon_edges = mon_edges + 1;
    end
    sck_q = sck_out;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [7:0] c);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = c;
    @(negedge clk); ctrl_we = 1'b0;
    cur_ctrl = c;
  endtask

  task automatic master_xfer(input logic [7:0] c, input logic [7:0] txb, input logic [7:0] mb);
    int d0;
    write_ctrl(c);
    h_exp = exp_half(c[2], c[1:0]);
    bench_miso = mb; mon_k = 0; mon_edges = 0; gap_err = 0; mon_mosi = '0; width_err = 0;
    d0 = done_cnt;
    @(negedge clk); tx_valid = 1'b1; tx_data = txb;
    chk("R8", "tx_ready when idle", tx_ready, 1);
    @(negedge clk); tx_valid = 1'b0; mon_last = cyc; mon_en = 1'b1;
    chk("R8", "busy after accept", busy, 1);
    chk("R4", "sck idle before first edge", sck_out, c[4]);
    if (!c[3]) chk("R6", "first bit early", mosi_out, txb[bitpos(c[6], 0)]);
    for (int i = 0; i < 3000 && done_cnt == d0; i++) @(negedge clk);
    @(negedge clk);
    mon_en = 1'b0;
    chk("R9", "one done strobe", done_cnt - d0, 1);
    chk("R9", "strobe width", width_err, 0);
    chk("R7", "received byte", rx_cap, mb);
    chk("R7", "sent byte", mon_mosi, txb);
    chk("R6", "edge count", mon_edges, 16);
    chk("R5", "half period gaps", gap_err, 0);
    chk("R9", "busy cleared", busy, 0);
    chk("R4", "sck idle after", sck_out, c[4]);
  endtask

  task automatic slave_xfer(input logic [7:0] c, input logic [7:0] txb, input logic [7:0] mb, input int stop_at);
    int d0, k;
    logic [7:0] got;
    logic samp;
    write_ctrl(c);
    sck_in = c[4]; ss_n_in = 1'b1;
    d0 = done_cnt;
    @(negedge clk); tx_valid = 1'b1; tx_data = txb;
    @(negedge clk); tx_valid = 1'b0;
    chk("R10", "slave idle after load", busy, 0);
    repeat (4) @(negedge clk);
    ss_n_in = 1'b0;
    if (!c[3]) mosi_in = mb[bitpos(c[6], 0)];
    repeat (8) @(negedge clk);
    got = '0; k = 0;
    for (int e = 1; e <= stop_at; e++) begin
      samp = ((e % 2) == 1) ^ c[3];
      if (samp) begin got[bitpos(c[6], k)] = miso_out; k++; end
      sck_in = ~sck_in;
      if (!samp && e != 16) mosi_in = mb[bitpos(c[6], c[3] ? (e - 1) / 2 : e / 2)];
      repeat (8) @(negedge clk);
    end
    if (stop_at == 16) begin
      chk("R10", "slave done", done_cnt - d0, 1);
      chk("R10", "slave received", rx_cap, mb);
      chk("R7", "slave sent", got, txb);
      ss_n_in = 1'b1;
      repeat (6) @(negedge clk);
    end else begin
      ss_n_in = 1'b1;
      repeat (6) @(negedge clk);
      chk("R10", "select abort busy", busy, 0);
      chk("R10", "select abort no done", done_cnt - d0, 0);
    end
  endtask

  initial begin
    logic [7:0] c;
    int d0;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    chk("R1", "ctrl reset", ctrl_rdata, 8'h00);
    chk("R1", "busy reset", busy, 0);
    chk("R1", "rx_valid reset", rx_valid, 0);
    chk("R1", "sck reset", sck_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "tx_ready reset", tx_ready, 0);

    write_ctrl(8'h5A);
    chk("R2", "ctrl readback", ctrl_rdata, 8'h5A);
    write_ctrl(8'hA5);
    chk("R2", "ctrl readback 2", ctrl_rdata, 8'hA5);

    // R3: disabled master ignores offered bytes
    write_ctrl(8'h30);
    d0 = done_cnt;
    chk("R3", "tx_ready disabled", tx_ready, 0);
    tx_valid = 1'b1; tx_data = 8'h3C;
    repeat (10) @(negedge clk);
    tx_valid = 1'b0;
    repeat (100) @(negedge clk);
    chk("R3", "busy disabled", busy, 0);
    chk("R3", "sck idle disabled", sck_out, 1);
    chk("R3", "no done disabled", done_cnt - d0, 0);

    // Directed: every rate code, cycling polarity, phase and order
    for (int r = 0; r < 8; r++) begin
      c = {1'b1, 1'(r >> 1), 1'b1, 1'(r), 1'(r >> 2), 3'(r)};
      master_xfer(c, 8'(8'h81 ^ (r * 37)), 8'(8'h5E + r * 19));
    end
    master_xfer(8'hA0, 8'h00, 8'hFF);
    master_xfer(8'hFC, 8'hFF, 8'h00);

    // Constrained random master transfers
    for (int i = 0; i < 10; i++) begin
      c = {1'b1, 1'($urandom), 1'b1, 3'($urandom), 2'($urandom)};
      master_xfer(c, 8'($urandom), 8'($urandom));
    end

    // R11: control write aborts a running transfer
    write_ctrl(8'hA3);
    d0 = done_cnt;
    @(negedge clk); tx_valid = 1'b1; tx_data = 8'h96;
    @(negedge clk); tx_valid = 1'b0;
    repeat (300) @(negedge clk);
    chk("R11", "busy mid transfer", busy, 1);
    write_ctrl(8'hB3);
    chk("R11", "busy after abort", busy, 0);
    chk("R11", "sck to new idle", sck_out, 1);
    repeat (2500) @(negedge clk);
    chk("R11", "no done after abort", done_cnt - d0, 0);

    // R12: control write and offered byte in the same cycle
    write_ctrl(8'hA0);
    d0 = done_cnt;
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = 8'hB8; tx_valid = 1'b1; tx_data = 8'h77;
    #1 chk("R12", "tx_ready during ctrl write", tx_ready, 0);
    @(negedge clk); ctrl_we = 1'b0; tx_valid = 1'b0; cur_ctrl = 8'hB8;
    chk("R12", "no start", busy, 0);
    chk("R12", "ctrl taken", ctrl_rdata, 8'hB8);
    repeat (40) @(negedge clk);
    chk("R12", "still idle", busy, 0);
    chk("R12", "sck idle level", sck_out, 1);
    chk("R12", "no done", done_cnt - d0, 0);

    // Slave mode: directed modes then random
    slave_xfer(8'h80, 8'hC5, 8'h3A, 16);
    slave_xfer(8'hC8, 8'h1E, 8'hB4, 16);
    slave_xfer(8'h90, 8'h6D, 8'h92, 16);
    slave_xfer(8'hD8, 8'hE1, 8'h07, 16);
    for (int i = 0; i < 4; i++) begin
      c = {1'b1, 1'($urandom), 1'b0, 2'($urandom), 3'($urandom)};
      slave_xfer(c, 8'($urandom), 8'($urandom), 16);
    end
    slave_xfer(8'h80, 8'h55, 8'hAA, 5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired act=%0d exp=0", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule